// File: doc/BRIEF.md
# Host Schedule Traversal Sequencer

This block chooses, for each 125 µs microframe of a USB 2.0 host controller, which shared-memory schedule the controller works from. When the periodic schedule is enabled, a microframe start makes the sequencer build the address of one frame list element from the periodic base register and the frame index. It reads that element, which is a link pointer. It then walks the chain of schedule structures horizontally, reading the next-link pointer held in the first dword of each structure.

Each structure the sequencer reaches is offered on an execute port. The sequencer holds it there until the transaction engine acknowledges it. When a link arrives with its terminate bit set, the periodic walk stops. The sequencer then moves straight to the asynchronous list head and keeps circling that list until the microframe end strobe. The end strobe also cancels any walk still in progress.

Top module: `sched_walker`

## Requirements
- R1: While reset is asserted and right after it, `ex_valid` and `rd_req` are low.
- R2: A microframe start seen while idle with `per_en` high raises `rd_req` for one cycle, on the next cycle. The address is {`per_base`[31:12], `frame_idx`[12:3], 2'b00}, so `frame_idx` bits 13 and 2:0 have no effect.
- R3: A returned link pointer without its terminate bit names the next structure. Its address is link[31:5] with bits 4:0 zero, and its type is link[2:1]. These appear on `ex_addr` and `ex_type`, with `ex_async` low during the periodic walk.
- R4: After each acknowledge, one read is issued at the acknowledged structure's address, which is where its next link lies. No second read is issued before `rd_valid` returns.
- R5: A link with bit 0 set during the periodic walk ends that walk. If `async_en` is high, the next element is the async head: {`async_head`[31:5], 5'b0}, type 2'b01, `ex_async` high. It is offered without any read of the async list beforehand.
- R6: In the asynchronous list, bit 0 of a link is ignored. The sequencer follows every link, circling until the end strobe.
- R7: A microframe start with `per_en` low and `async_en` high offers the async head on the next cycle, with no read.
- R8: A microframe start with both enables low causes no read and no execute request.
- R9: When the periodic walk ends and `async_en` is low, the sequencer goes idle and stays silent for the rest of the microframe.
- R10: `uframe_end` clears `ex_valid` and `rd_req` on the next cycle, even while a read is outstanding. A response that arrives afterwards is ignored, and the next start begins again at the frame list.
- R11: While `ex_valid` is high and no acknowledge has come, `ex_addr` and `ex_type` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| per_base | input | 32 | Periodic frame list base; bits 31:12 used |
| frame_idx | input | 14 | Frame index; bits 12:3 select the list element |
| async_head | input | 32 | Async list head address; bits 31:5 used |
| per_en | input | 1 | Periodic schedule enable |
| async_en | input | 1 | Asynchronous schedule enable |
| uframe_start | input | 1 | Microframe start pulse |
| uframe_end | input | 1 | Microframe end pulse |
| rd_req | output | 1 | One-cycle memory read request |
| rd_addr | output | 32 | Read address, dword aligned |
| rd_valid | input | 1 | Read response strobe |
| rd_data | input | 32 | Read response data (a link pointer) |
| ex_valid | output | 1 | Element offered for execution |
| ex_addr | output | 32 | Element address, 32-byte aligned |
| ex_type | output | 2 | Element type code from the link |
| ex_async | output | 1 | High when the element is from the async list |
| ex_ack | input | 1 | Execution done pulse |

## Verification
The bench targets several corner cases:

- A frame index with bits 13 and 2:0 set. A design that spliced the wrong slice would read the wrong frame list element.
- A terminate bit in the periodic walk. A design that read the async list before the periodic end, or that kept following the terminated link, would break the expected read order.
- A terminate bit inside the async ring. It must be ignored; a design that stopped there would fall silent too early.
- An end strobe while a read is still outstanding, with a slow memory. A design that accepted the late response would offer an element after the microframe closed.
- Both schedules disabled, and periodic-only with an empty frame. Either case exposes stray reads or execute requests.

// File: rtl/sched_walker.sv
module sched_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] per_base,
  input  logic [13:0] frame_idx,
  input  logic [31:0] async_head,
  input  logic        per_en,
  input  logic        async_en,
  input  logic        uframe_start,
  input  logic        uframe_end,
  output logic        rd_req,
  output logic [31:0] rd_addr,
  input  logic        rd_valid,
  input  logic [31:0] rd_data,
  output logic        ex_valid,
  output logic [31:0] ex_addr,
  output logic [1:0]  ex_type,
  output logic        ex_async,
  input  logic        ex_ack
);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_EXEC} state_t;

  localparam logic [1:0] HEAD_TYPE = 2'b01;

  state_t      st;
  logic [26:0] cur;
  logic [1:0]  cur_ty;
  logic        in_async;

  wire [31:0] list_addr = {per_base[31:12], frame_idx[12:3], 2'b00};
  wire [26:0] head_ptr  = async_head[31:5];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cur      <= '0;
      cur_ty   <= '0;
      in_async <= 1'b0;
      rd_addr  <= '0;
    end else if (uframe_end) begin
      st       <= S_IDLE;
      in_async <= 1'b0;
    end else begin
      case (st)
        S_IDLE:
          if (uframe_start) begin
            if (per_en) begin
              st       <= S_REQ;
              rd_addr  <= list_addr;
              in_async <= 1'b0;
            end else if (async_en) begin
              st       <= S_EXEC;
              cur      <= head_ptr;
              cur_ty   <= HEAD_TYPE;
              in_async <= 1'b1;
            end
          end
        S_REQ: st <= S_WAIT;
        S_WAIT:
          if (rd_valid) begin
            if (!in_async && rd_data[0]) begin
              if (async_en) begin
                st       <= S_EXEC;
                cur      <= head_ptr;
                cur_ty   <= HEAD_TYPE;
                in_async <= 1'b1;
              end else begin
                st <= S_IDLE;
              end
            end else begin
              st     <= S_EXEC;
              cur    <= rd_data[31:5];
              cur_ty <= rd_data[2:1];
            end
          end
        S_EXEC:
          if (ex_ack) begin
            st      <= S_REQ;
            rd_addr <= {cur, 5'b0};
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign rd_req   = (st == S_REQ);
  assign ex_valid = (st == S_EXEC);
  assign ex_addr  = {cur, 5'b0};
  assign ex_type  = cur_ty;
  assign ex_async = in_async;

  // R11
  ex_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ex_valid && !ex_ack && !uframe_end |=> ex_valid && $stable(ex_addr) && $stable(ex_type));

  // R10
  end_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uframe_end |=> !ex_valid && !rd_req);

  // R2
  list_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE && uframe_start && per_en && !uframe_end
    |=> rd_req && rd_addr == {$past(per_base[31:12]), $past(frame_idx[12:3]), 2'b00});

  // R7
  async_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE && uframe_start && !per_en && async_en && !uframe_end
    |=> ex_valid && ex_async && !rd_req && ex_addr == {$past(async_head[31:5]), 5'b0});

  // R8
  idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE && uframe_start && !per_en && !async_en |=> !rd_req && !ex_valid);

endmodule

// File: tb/sched_walker_test.sv
module sched_walker_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [31:0] per_base = '0, async_head = '0, rd_data = '0;
  logic [13:0] frame_idx = '0;
  logic        per_en = 0, async_en = 0, uframe_start = 0, uframe_end = 0;
  logic        rd_valid = 0, ex_ack = 0;
  logic        rd_req, ex_valid, ex_async;
  logic [31:0] rd_addr, ex_addr;
  logic [1:0]  ex_type;

  sched_walker uut (.clk, .rst_n, .per_base, .frame_idx, .async_head, .per_en, .async_en,
    .uframe_start, .uframe_end, .rd_req, .rd_addr, .rd_valid, .rd_data,
    .ex_valid, .ex_addr, .ex_type, .ex_async, .ex_ack);

  int errors = 0, checks = 0, lat = 2;
  logic [31:0] exp_rd[$];
  logic [34:0] exp_ex[$];
  logic [31:0] mem [logic [31:0]];

  task automatic chk(bit ok, string req, logic [34:0] act, logic [34:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(logic [31:0] a, logic [1:0] t, logic term);
    return {a[31:5], 2'b00, t, term};
  endfunction

  // memory model
  int pend = 0;
  logic [31:0] pdata;
  always @(negedge clk) begin
    rd_valid = 1'b0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin rd_valid = 1'b1; rd_data = pdata; end
    end
    if (rd_req) begin
      if (exp_rd.size() == 0) chk(0, "R4 unexpected read", {3'b0, rd_addr}, 0);
      else begin
        chk(rd_addr == exp_rd[0], "R4 read order/address", {3'b0, rd_addr}, {3'b0, exp_rd[0]});
        void'(exp_rd.pop_front());
      end
      pdata = mem.exists(rd_addr) ? mem[rd_addr] : 32'h1;
      pend  = lat;
    end
  end

  // scoreboard monitor
  int waitc = 0;
  logic [31:0] seen;
  always @(negedge clk) begin
    if (ex_ack) begin ex_ack = 1'b0; waitc = 0; end
    else if (!ex_valid) waitc = 0;
    else if (exp_ex.size() > 0) begin
      if (waitc == 0) seen = ex_addr;
      waitc++;
      if (waitc == 3) begin
        chk({ex_async, ex_type, ex_addr} == exp_ex[0], "R3/R5/R6 execute item",
            {ex_async, ex_type, ex_addr}, exp_ex[0]);
        chk(ex_addr == seen, "R11 held stable", {3'b0, ex_addr}, {3'b0, seen});
        void'(exp_ex.pop_front());
        ex_ack = 1'b1;
      end
    end
  end

  task automatic pulse_start();
    @(negedge clk) uframe_start = 1;
    @(negedge clk) uframe_start = 0;
  endtask

  task automatic pulse_end();
    @(negedge clk) uframe_end = 1;
    @(negedge clk) uframe_end = 0;
    chk(!ex_valid && !rd_req, "R10 end aborts", {33'b0, ex_valid, rd_req}, 0);
  endtask

  task automatic watch(int n, string req);
    int cnt = 0;
    repeat (n) @(negedge clk) if (rd_req || ex_valid) cnt++;
    chk(cnt == 0, req, cnt, 0);
  endtask

  task automatic drain();
    while (exp_ex.size() != 0 || exp_rd.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual hung run, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] la, la2, a, b, h, c;
    a = 32'h0001_0020; b = 32'h0001_0040; h = 32'h0002_0000; c = 32'h0002_0060;
    per_base = 32'h1234_5ABC; frame_idx = 14'h22AD; async_head = 32'h0002_001F;
    la  = {per_base[31:12], frame_idx[12:3], 2'b00};
    la2 = {per_base[31:12], 10'd3, 2'b00};
    mem[la] = mk(a, 2'd0, 0); mem[a] = mk(b, 2'd2, 0); mem[b] = mk(32'h0003_0000, 2'd0, 1);
    mem[h] = mk(c, 2'd1, 0); mem[c] = mk(h, 2'd1, 1);
    mem[la2] = mk(a, 2'd0, 1);

    repeat (3) @(negedge clk);
    chk(!ex_valid && !rd_req, "R1 in reset", {33'b0, ex_valid, rd_req}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!ex_valid && !rd_req, "R1 after reset", {33'b0, ex_valid, rd_req}, 0);

    // S1: periodic chain then async ring (R2 R3 R4 R5 R6)
    per_en = 1; async_en = 1;
    exp_rd = '{la, a, b, h, c, h};
    exp_ex.push_back({1'b0, 2'd0, a});
    exp_ex.push_back({1'b0, 2'd2, b});
    exp_ex.push_back({1'b1, 2'd1, h});
    exp_ex.push_back({1'b1, 2'd1, c});
    exp_ex.push_back({1'b1, 2'd1, h});
    pulse_start();
    drain();
    pulse_end();

    // S2: periodic disabled (R7)
    per_en = 0;
    exp_rd = '{h, c, h};
    exp_ex.push_back({1'b1, 2'd1, h});
    exp_ex.push_back({1'b1, 2'd1, c});
    exp_ex.push_back({1'b1, 2'd1, h});
    pulse_start();
    drain();
    pulse_end();

    // S3: both disabled (R8)
    async_en = 0;
    pulse_start();
    watch(15, "R8 no activity when both disabled");
    pulse_end();

    // S4: empty periodic frame, async disabled (R9)
    per_en = 1; frame_idx = 14'h0018;
    exp_rd.push_back(la2);
    pulse_start();
    drain();
    watch(15, "R9 silent after periodic end");
    chk(exp_rd.size() == 0, "R9 frame list read", exp_rd.size(), 0);
    pulse_end();

    // S5: abort with read outstanding, then restart (R10)
    async_en = 1; frame_idx = 14'h22AD; lat = 6;
    exp_rd.push_back(la);
    pulse_start();
    repeat (2) @(negedge clk);
    pulse_end();
    watch(12, "R10 late response ignored");
    lat = 2;
    exp_rd = '{la, a};
    exp_ex.push_back({1'b0, 2'd0, a});
    pulse_start();
    drain();
    chk(ex_valid && ex_addr == b && !ex_async, "R10 restart from frame list",
        {ex_async, ex_type, ex_addr}, {1'b0, 2'd2, b});
    pulse_end();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule